// File: doc/BRIEF.md
# Latching Seven-Segment Digit Decoder

This block drives one digit of a seven-segment display from a 4-bit 8421 BCD value. The input nibble passes through a data latch that can either follow the input or hold the last value it took. A fixed font turns the nibble into the seven segment signals a to g. Three override inputs act on top of the font. A forced-blank input turns the digit dark. A lamp-test input lights every segment. A ripple-blank input suppresses a zero digit.

Several instances can be chained for a multi-digit readout. The ripple-blank output of one digit feeds the ripple-blank input of the next less significant digit. The most significant digit has its ripple-blank input tied low. The chain then suppresses leading zeros until it reaches the first nonzero digit. The decimal point is not produced here.

Three build parameters suit the block to the display:
- `ACTIVE_LOW` sets the segment polarity: 0 for a common-cathode display, 1 for a common-anode display.
- `FONT_MODE` chooses between blanking codes 10 to 15 and giving each of them its own non-numeric glyph.
- `TAILS` chooses whether 6 and 9 are drawn with their tail segment.

All outputs are registered. Every effect of an input appears on the outputs one clock after the edge that samples it.

Top module: `seg7_latch_decoder`

## Requirements
- R1: While `latch_en` is 1 at a rising edge, the outputs after that edge show the decode of the `digit_in` value sampled at that edge. That value is also stored in the latch.
- R2: While `latch_en` is 0, changes on `digit_in` have no effect. The digit shown is the value stored at the last edge where `latch_en` was 1.
- R3: When `blank_n` is 0, all seven segments are dark after the next edge. This holds whatever the digit, `lamp_test` or `ripple_in_n` hold, and `ripple_out_n` is 1.
- R4: When `blank_n` is 1 and `lamp_test` is 1, all seven segments are lit after the next edge, whatever the digit or `ripple_in_n`. `ripple_out_n` is 1.
- R5: With `blank_n` 1, `lamp_test` 0, `ripple_in_n` 0 and a selected digit of 0, all segments are dark and `ripple_out_n` is 0.
- R6: `ripple_in_n` has no effect on a nonzero digit. `ripple_out_n` is 0 only in the case of R5 and is 1 in every other case.
- R7: Segment bit order is `seg[0]`=a through `seg[6]`=g. In active-high form the digits are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 7=0x07 and 8=0x7F.
- R8: With `TAILS`=1, 6=0x7D and 9=0x6F. With `TAILS`=0, 6=0x7C (a dark) and 9=0x67 (d dark).
- R9: With `FONT_MODE`=0, codes 10 to 15 are dark. With `FONT_MODE`=1, codes 10 to 15 show 0x58, 0x4C, 0x62, 0x69, 0x78 and 0x40.
- R10: With `ACTIVE_LOW`=0 a lit segment is 1. With `ACTIVE_LOW`=1 every output bit is the inverse of its active-high value, and a lit segment is 0.
- R11: A synchronous reset makes all segments dark and sets `ripple_out_n` to 1. It also clears the stored digit to 0, so a held display after reset shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_en | input | 1 | 1: latch follows `digit_in`; 0: latch holds |
| digit_in | input | 4 | BCD digit (8421) |
| lamp_test | input | 1 | 1 lights every segment |
| blank_n | input | 1 | 0 forces the digit dark |
| ripple_in_n | input | 1 | 0 suppresses a zero digit |
| seg | output | 7 | Segment drive, bit 0 = a ... bit 6 = g |
| ripple_out_n | output | 1 | 0 when this digit was suppressed as a ripple zero |

## Verification
The bench probes the override priority.
- It drives forced blank together with lamp test, which catches a design that lets lamp test win and shows 8.
- It drives lamp test with a zero digit and ripple blank asserted, which catches a design that goes dark or pulls the ripple output low.
- It applies ripple blank to every nonzero code, which catches a decoder that suppresses more than the zero digit.
- It changes the input while the latch holds, which exposes a latch that leaks new data or that stores the value from the wrong cycle.

Two instances run with opposite polarity, font and tail settings. This exposes a wrong glyph for 6, 9 or codes 10 to 15, and an inversion applied in the wrong place.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  // which source drives the segment register
  typedef enum logic [1:0] {
    SRC_DARK   = 2'd0,
    SRC_LAMP   = 2'd1,
    SRC_RIPPLE = 2'd2,
    SRC_GLYPH  = 2'd3
  } src_e;

  localparam seg_t PAT_NONE = '0;
  localparam seg_t PAT_ALL  = '1;
endpackage

// File: rtl/seg7_in_latch.sv
module seg7_in_latch
  import seg7_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         follow,
  input  logic [W-1:0] d,
  output logic [W-1:0] sel
);
  logic [W-1:0] held_q;

  // clock-enabled register stands in for the transparent latch
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (follow) begin
      held_q <= d;
    end
  end

  // follow: pass the live input; hold: present the stored nibble
  always_comb begin
    sel = follow ? d : held_q;
  end
endmodule

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
  import seg7_pkg::*;
#(
  parameter int FONT_MODE = 1,
  parameter int TAILS     = 1
) (
  input  digit_t code,
  output seg_t   pat
);
  localparam seg_t SIX_PAT  = (TAILS != 0) ? 7'h7D : 7'h7C;
  localparam seg_t NINE_PAT = (TAILS != 0) ? 7'h6F : 7'h67;

  seg_t num_pat;
  seg_t ext_pat;

  always_comb begin
    case (code[2:0])
      3'd0:    num_pat = 7'h3F;
      3'd1:    num_pat = 7'h06;
      3'd2:    num_pat = 7'h5B;
      3'd3:    num_pat = 7'h4F;
      3'd4:    num_pat = 7'h66;
      3'd5:    num_pat = 7'h6D;
      3'd6:    num_pat = SIX_PAT;
      default: num_pat = 7'h07;
    endcase
    if (code == 4'd8) num_pat = 7'h7F;
    if (code == 4'd9) num_pat = NINE_PAT;
  end

  generate
    if (FONT_MODE == 0) begin : g_blank_ext
      always_comb ext_pat = PAT_NONE;
    end else begin : g_glyph_ext
      always_comb begin
        case (code)
          4'd10:   ext_pat = 7'h58;
          4'd11:   ext_pat = 7'h4C;
          4'd12:   ext_pat = 7'h62;
          4'd13:   ext_pat = 7'h69;
          4'd14:   ext_pat = 7'h78;
          default: ext_pat = 7'h40;
        endcase
      end
    end
  endgenerate

  always_comb begin
    pat = (code > 4'd9) ? ext_pat : num_pat;
  end

  always_comb begin
    if (code <= 4'd9) begin
      AST_DIGIT_VISIBLE: assert (pat != PAT_NONE); // R7
    end
  end
endmodule

// File: rtl/seg7_blank_sel.sv
module seg7_blank_sel
  import seg7_pkg::*;
(
  input  logic  blank_n,
  input  logic  lamp_test,
  input  logic  ripple_in_n,
  input  logic  is_zero,
  input  seg_t  glyph,
  output seg_t  pat,
  output logic  ripple_out_n,
  output src_e  src
);
  // priority: forced blank, lamp test, ripple zero, font
  always_comb begin
    if (!blank_n)                   src = SRC_DARK;
    else if (lamp_test)             src = SRC_LAMP;
    else if (!ripple_in_n && is_zero) src = SRC_RIPPLE;
    else                            src = SRC_GLYPH;
  end

  always_comb begin
    unique case (src)
      SRC_DARK:   pat = PAT_NONE;
      SRC_LAMP:   pat = PAT_ALL;
      SRC_RIPPLE: pat = PAT_NONE;
      default:    pat = glyph;
    endcase
    ripple_out_n = (src != SRC_RIPPLE);
  end
endmodule

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder
  import seg7_pkg::*;
#(
  parameter int ACTIVE_LOW = 0,
  parameter int FONT_MODE  = 1,
  parameter int TAILS      = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               latch_en,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               lamp_test,
  input  logic               blank_n,
  input  logic               ripple_in_n,
  output logic [SEG_W-1:0]   seg,
  output logic               ripple_out_n
);
  localparam seg_t SEG_OFF = (ACTIVE_LOW != 0) ? PAT_ALL : PAT_NONE;
  localparam seg_t SEG_ON  = ~SEG_OFF;

  digit_t digit_sel;
  seg_t   glyph;
  seg_t   pat_hi;
  seg_t   pat_drv;
  logic   rbo_d;
  src_e   src;
  seg_t   seg_q;
  logic   rbo_q;

  seg7_in_latch #(.W(DIGIT_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .follow (latch_en),
    .d      (digit_in),
    .sel    (digit_sel)
  );

  seg7_glyph_rom #(.FONT_MODE(FONT_MODE), .TAILS(TAILS)) u_rom (
    .code (digit_sel),
    .pat  (glyph)
  );

  seg7_blank_sel u_sel (
    .blank_n      (blank_n),
    .lamp_test    (lamp_test),
    .ripple_in_n  (ripple_in_n),
    .is_zero      (digit_sel == '0),
    .glyph        (glyph),
    .pat          (pat_hi),
    .ripple_out_n (rbo_d),
    .src          (src)
  );

  generate
    if (ACTIVE_LOW != 0) begin : g_anode
      always_comb pat_drv = ~pat_hi;
    end else begin : g_cathode
      always_comb pat_drv = pat_hi;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_OFF;
      rbo_q <= 1'b1;
    end else begin
      seg_q <= pat_drv;
      rbo_q <= rbo_d;
    end
  end

  assign seg          = seg_q;
  assign ripple_out_n = rbo_q;

  AST_FORCED_DARK: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> (seg == SEG_OFF && ripple_out_n)); // R3
  AST_LAMP_FULL: assert property (@(posedge clk) disable iff (rst)
    (blank_n && lamp_test) |=> (seg == SEG_ON && ripple_out_n)); // R4
  AST_RIPPLE_DARK: assert property (@(posedge clk) disable iff (rst)
    !ripple_out_n |-> seg == SEG_OFF); // R5
  AST_RIPPLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !ripple_out_n |-> (!$past(ripple_in_n) && $past(digit_sel) == '0)); // R6
  AST_SRC_KNOWN: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_GLYPH) |=> (seg == (($past(glyph)) ^ SEG_OFF))); // R10
endmodule

// File: tb/sim_seg7_latch_decoder.sv
`timescale 1ns/1ps
module sim_seg7_latch_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic latch_en = 1'b0;
  logic [3:0] digit_in = 4'd0;
  logic lamp_test = 1'b0;
  logic blank_n = 1'b1;
  logic ripple_in_n = 1'b1;
  logic [6:0] seg0, seg1;
  logic rbo0, rbo1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // u0: active high, glyph font, tails; u1: active low, blank font, no tails
  seg7_latch_decoder u0 (
    .clk(clk), .rst(rst), .latch_en(latch_en), .digit_in(digit_in),
    .lamp_test(lamp_test), .blank_n(blank_n), .ripple_in_n(ripple_in_n),
    .seg(seg0), .ripple_out_n(rbo0));

  seg7_latch_decoder #(.ACTIVE_LOW(1), .FONT_MODE(0), .TAILS(0)) u1 (
    .clk(clk), .rst(rst), .latch_en(latch_en), .digit_in(digit_in),
    .lamp_test(lamp_test), .blank_n(blank_n), .ripple_in_n(ripple_in_n),
    .seg(seg1), .ripple_out_n(rbo1));

  logic [6:0] exp0_q[$];
  logic [6:0] exp1_q[$];
  logic       expr_q[$];
  string      tag_q[$];
  logic [3:0] held = 4'd0;

  function automatic logic [6:0] ref_glyph(input logic [3:0] c, input bit tails, input bit glyphs);
    case (c)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return tails ? 7'h7D : 7'h7C;
      4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return tails ? 7'h6F : 7'h67;
      default: begin
        if (!glyphs) return 7'h00;
        case (c)
          4'd10: return 7'h58; 4'd11: return 7'h4C; 4'd12: return 7'h62;
          4'd13: return 7'h69; 4'd14: return 7'h78; default: return 7'h40;
        endcase
      end
    endcase
  endfunction

  task automatic drive(input bit le, input logic [3:0] d, input bit lt,
                       input bit bn, input bit rn, input string tag);
    logic [3:0] s;
    logic [6:0] p0, p1;
    logic r;
    @(negedge clk);
    latch_en = le; digit_in = d; lamp_test = lt; blank_n = bn; ripple_in_n = rn;
    s = le ? d : held;
    if (le) held = d;
    r = 1'b1;
    if (!bn) begin p0 = 7'h00; p1 = 7'h00; end
    else if (lt) begin p0 = 7'h7F; p1 = 7'h7F; end
    else if (!rn && s == 4'd0) begin p0 = 7'h00; p1 = 7'h00; r = 1'b0; end
    else begin p0 = ref_glyph(s, 1'b1, 1'b1); p1 = ref_glyph(s, 1'b0, 1'b0); end
    exp0_q.push_back(p0);
    exp1_q.push_back(~p1);
    expr_q.push_back(r);
    tag_q.push_back(tag);
  endtask

  // monitor: one expected item per edge after it was pushed
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp0_q.size() > 0) begin
        logic [6:0] e0, e1;
        logic er;
        string t;
        e0 = exp0_q.pop_front(); e1 = exp1_q.pop_front();
        er = expr_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (seg0 !== e0 || rbo0 !== er || seg1 !== e1 || rbo1 !== er) begin
          fails++;
          $display("FAIL %s: u0 seg=%h rbo=%b u1 seg=%h rbo=%b, expected u0 seg=%h u1 seg=%h rbo=%b",
                   t, seg0, rbo0, seg1, rbo1, e0, e1, er);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (seg0 !== 7'h00 || seg1 !== 7'h7F || rbo0 !== 1'b1 || rbo1 !== 1'b1) begin
      fails++;
      $display("FAIL R11: seg0=%h seg1=%h rbo=%b%b expected 00 7f 11", seg0, seg1, rbo0, rbo1);
    end
    @(negedge clk);
    rst = 1'b0;
    // R11: held latch after reset shows 0
    drive(0, 4'd7, 0, 1, 1, "R11 held zero after reset");
    // R1 R7 R8 R9 R10: transparent sweep of all codes
    for (int i = 0; i < 16; i++) drive(1, 4'(i), 0, 1, 1, "R1 R7 R8 R9 R10 font sweep");
    // R2: hold last value while input moves
    drive(1, 4'd5, 0, 1, 1, "R1 load 5");
    for (int i = 0; i < 16; i++) drive(0, 4'(i), 0, 1, 1, "R2 hold ignores input");
    drive(1, 4'd6, 0, 1, 1, "R1 reload 6");
    drive(0, 4'd0, 0, 1, 0, "R2 R6 held 6 with ripple in");
    // R3: forced blank beats lamp test and everything else
    for (int i = 0; i < 16; i++) drive(1, 4'(i), i[0], 0, i[1], "R3 forced dark");
    // R4: lamp test with ripple zero
    for (int i = 0; i < 16; i++) drive(1, 4'(i), 1, 1, 0, "R4 lamp test");
    // R5 R6: ripple blank on every code
    for (int i = 0; i < 16; i++) drive(1, 4'(i), 0, 1, 0, "R5 R6 ripple blank");
    drive(1, 4'd0, 0, 1, 1, "R6 zero shown without ripple in");
    drive(0, 4'd9, 0, 1, 0, "R5 held zero ripple blanked");
    // mixed vectors
    for (int i = 0; i < 300; i++) begin
      int unsigned v;
      v = $urandom;
      drive(v[0], 4'(v[7:4]), (v[11:9] == 3'd0), (v[14:12] != 3'd0), v[15], "R1 R2 R3 R4 R5 R6 mixed");
    end
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule